// File: doc/BRIEF.md
# Event Statistics Counter Bank

This block holds a bank of independent event counters, 256 of them by default and each twice the width of one memory word (32 bits by default). Each count is split across two dual-port memories of equal shape. One memory stores the lower half of every count and the other stores the upper half. Each memory has a port that only reads and a separate port that only writes. The block includes behavioural models of both memories. If a memory port reads a location in the same cycle that the other port writes it, the read returns a corrupted word. The design never lets such a word reach an output or a stored count.

A host pulses `incEvent` to add one to the counter selected by `eventId`. It pulses `readReq` to fetch that counter. A fetched count appears on `countOut` with a one-cycle `countValid` strobe. Each increment is a pipelined read-modify-write: the block registers the request, reads both memories, registers the read data, then writes back the sum.

After reset, the block writes zero to every entry, one address per cycle. Only then does it raise `cntReady`. Requests that arrive while `cntReady` is low are dropped. The host never asserts `incEvent` and `readReq` in the same cycle.

Top module: `evt_stat_counter`

## Requirements
- R1: While `rst` is high, `cntReady` and `countValid` are low. After `rst` falls, the block writes zero to addresses 0 up to the last address, one per cycle. `cntReady` becomes visible exactly NUM_CNT rising edges after reset release and stays high until the next reset.
- R2: Once `cntReady` is high, every counter reads zero. This holds even when the memory held nonzero counts before the reset.
- R3: An `incEvent` pulse sampled while `cntReady` is high adds exactly one to the counter selected by `eventId` and leaves every other counter unchanged.
- R4: The lower half of a count occupies bits HALF_W-1:0 and the upper half occupies the bits above it. The lower half carries into the upper half. A count of all ones wraps to zero.
- R5: A `readReq` pulse in cycle c, sampled while `cntReady` is high, gives exactly one `countValid` cycle, in cycle c+4. `countOut` holds the selected count during that cycle.
- R6: A read returns a count that includes every increment accepted in an earlier cycle. This holds when the read follows an increment of the same counter by 1, 2, 3 or more cycles, including the case where the memory read and the write-back hit the same address in the same cycle.
- R7: An `incEvent` or `readReq` that arrives while `cntReady` is low is ignored. It produces no strobe and changes no counter.
- R8: Reads issued on consecutive cycles are each answered, in request order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high; starts the clear sweep |
| incEvent | input | 1 | Add one to the selected counter |
| readReq | input | 1 | Fetch the selected counter |
| eventId | input | $clog2(NUM_CNT) | Counter index for the request |
| cntReady | output | 1 | High once the clear sweep has finished |
| countOut | output | 2*HALF_W | Fetched count |
| countValid | output | 1 | One-cycle strobe qualifying `countOut` |

## Verification
The hardest situation to reach from the ports is a same-address collision between a memory read and a write-back. The stale-read window is also hard to reach. The bench gets there by incrementing a counter and then reading it after gaps of one, two, three and four cycles. The carry into the upper half and the wrap from all ones are too far away at the default width. The bench therefore narrows each memory word to four bits, so both events occur within a few hundred increments spaced five cycles apart. A second reset, issued after the memory holds many counts, shows that the clear sweep really overwrites old data.

// File: rtl/evt_cnt_pkg.sv
package evt_cnt_pkg;
  // Per-cycle strobes from the control FSM to the datapath
  typedef struct packed {
    logic clearWr;   // clear sweep writes zero this cycle
    logic rdIssue;   // stage 1: memory read issued
    logic capture;   // stage 2: memory data registered
    logic incWrite;  // stage 3: write back incremented count
    logic rdDeliver; // stage 3: present count on the output
  } ctrlStrobes_t;
endpackage

// File: rtl/evt_cnt_ram.sv
module evt_cnt_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rdEn,
  input  logic [AW-1:0]    rdAddr,
  output logic [WIDTH-1:0] rdData,
  input  logic             portEnB,
  input  logic             wrEnB,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic             clash;

  // Same location written and read in one cycle: read word is corrupt
  assign clash = portEnB && wrEnB && (wrAddr == rdAddr);

  always_ff @(posedge clk) begin
    if (portEnB && wrEnB) mem[wrAddr] <= wrData;
    if (rdEn) rdData <= clash ? ~mem[rdAddr] : mem[rdAddr];
  end
endmodule

// File: rtl/evt_cnt_ctrl.sv
module evt_cnt_ctrl
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CNT = 256,
  parameter int ID_W    = $clog2(NUM_CNT)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            incEvent,
  input  logic            readReq,
  output logic            cntReady,
  output ctrlStrobes_t    strb,
  output logic [ID_W-1:0] clrAddr
);
  localparam int              STAGES    = 3;
  localparam logic [ID_W-1:0] LAST_ADDR = ID_W'(NUM_CNT - 1);

  logic              clearing;
  logic [STAGES-1:0] incPipe;
  logic [STAGES-1:0] rdPipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      clearing <= 1'b1;
      cntReady <= 1'b0;
      clrAddr  <= '0;
      incPipe  <= '0;
      rdPipe   <= '0;
    end else begin
      if (clearing) begin
        clrAddr <= clrAddr + 1'b1;
        if (clrAddr == LAST_ADDR) begin
          clearing <= 1'b0;
          cntReady <= 1'b1;
        end
      end
      incPipe <= {incPipe[STAGES-2:0], incEvent && cntReady};
      rdPipe  <= {rdPipe[STAGES-2:0], readReq && cntReady};
    end
  end

  always_comb begin
    strb.clearWr   = clearing;
    strb.rdIssue   = incPipe[0] | rdPipe[0];
    strb.capture   = incPipe[1] | rdPipe[1];
    strb.incWrite  = incPipe[2];
    strb.rdDeliver = rdPipe[2];
  end
endmodule

// File: rtl/evt_cnt_datapath.sv
module evt_cnt_datapath
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CNT = 256,
  parameter int HALF_W  = 16,
  parameter int ID_W    = $clog2(NUM_CNT),
  parameter int CNT_W   = 2 * HALF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strb,
  input  logic [ID_W-1:0]  clrAddr,
  input  logic [ID_W-1:0]  eventId,
  output logic [CNT_W-1:0] countOut,
  output logic             countValid,
  output logic             ramWrEn,
  output logic [ID_W-1:0]  ramWrAddr,
  output logic [CNT_W-1:0] ramWrData
);
  localparam int HALVES = 2;

  logic [ID_W-1:0]               idS1, idS2, idS3;
  logic [HALVES-1:0][HALF_W-1:0] ramRdHalf;
  logic [CNT_W-1:0]              ramRdWide;
  logic [CNT_W-1:0]              rdDataQ;
  logic [HALF_W:0]               loSum;
  logic [HALF_W-1:0]             hiSum;
  logic [CNT_W-1:0]              incSum;
  logic [CNT_W-1:0]              captured;
  logic                          lastWrValid;
  logic [ID_W-1:0]               lastWrId;
  logic [CNT_W-1:0]              lastWrData;
  logic                          fwdNow, fwdLast;

  // Request index travels alongside the control pipeline
  always_ff @(posedge clk) begin
    idS1 <= eventId;
    idS2 <= idS1;
    idS3 <= idS2;
  end

  // One memory per half of the count
  for (genvar h = 0; h < HALVES; h++) begin : g_half
    evt_cnt_ram #(
      .DEPTH(NUM_CNT),
      .WIDTH(HALF_W),
      .AW   (ID_W)
    ) u_ram (
      .clk    (clk),
      .rdEn   (strb.rdIssue),
      .rdAddr (idS1),
      .rdData (ramRdHalf[h]),
      .portEnB(ramWrEn),
      .wrEnB  (ramWrEn),
      .wrAddr (ramWrAddr),
      .wrData (ramWrData[h*HALF_W +: HALF_W])
    );
  end

  assign ramRdWide = ramRdHalf;

  // Split increment: lower half feeds its carry into the upper half
  always_comb begin
    loSum  = {1'b0, rdDataQ[HALF_W-1:0]} + (HALF_W+1)'(1);
    hiSum  = rdDataQ[CNT_W-1:HALF_W] + HALF_W'(loSum[HALF_W]);
    incSum = {hiSum, loSum[HALF_W-1:0]};
  end

  // Write port: clear sweep has priority; no increments run while clearing
  always_comb begin
    ramWrEn   = strb.clearWr | strb.incWrite;
    ramWrAddr = strb.clearWr ? clrAddr : idS3;
    ramWrData = strb.clearWr ? '0 : incSum;
  end

  // Forwarding covers stale reads and same-address collisions
  always_comb begin
    fwdNow  = strb.incWrite && (idS3 == idS2);
    fwdLast = lastWrValid && (lastWrId == idS2);
    if (fwdNow)       captured = incSum;
    else if (fwdLast) captured = lastWrData;
    else              captured = ramRdWide;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastWrValid <= 1'b0;
      lastWrId    <= '0;
      lastWrData  <= '0;
      rdDataQ     <= '0;
      countOut    <= '0;
      countValid  <= 1'b0;
    end else begin
      lastWrValid <= ramWrEn;
      lastWrId    <= ramWrAddr;
      lastWrData  <= ramWrData;
      if (strb.capture) rdDataQ <= captured;
      if (strb.rdDeliver) countOut <= rdDataQ;
      countValid <= strb.rdDeliver;
    end
  end
endmodule

// File: rtl/evt_stat_counter.sv
module evt_stat_counter
  import evt_cnt_pkg::*;
#(
  parameter int NUM_CNT = 256,
  parameter int HALF_W  = 16,
  parameter int ID_W    = $clog2(NUM_CNT)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  incEvent,
  input  logic                  readReq,
  input  logic [ID_W-1:0]       eventId,
  output logic                  cntReady,
  output logic [2*HALF_W-1:0]   countOut,
  output logic                  countValid
);
  localparam int CNT_W = 2 * HALF_W;

  ctrlStrobes_t     strb;
  logic [ID_W-1:0]  clrAddr;
  logic             ramWrEn;
  logic [ID_W-1:0]  ramWrAddr;
  logic [CNT_W-1:0] ramWrData;

  evt_cnt_ctrl #(
    .NUM_CNT(NUM_CNT),
    .ID_W   (ID_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .incEvent(incEvent),
    .readReq (readReq),
    .cntReady(cntReady),
    .strb    (strb),
    .clrAddr (clrAddr)
  );

  evt_cnt_datapath #(
    .NUM_CNT(NUM_CNT),
    .HALF_W (HALF_W),
    .ID_W   (ID_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .clrAddr   (clrAddr),
    .eventId   (eventId),
    .countOut  (countOut),
    .countValid(countValid),
    .ramWrEn   (ramWrEn),
    .ramWrAddr (ramWrAddr),
    .ramWrData (ramWrData)
  );
endmodule

// File: rtl/evt_stat_counter_chk.sv
module evt_stat_counter_chk #(
  parameter int ID_W  = 8,
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             incEvent,
  input logic             readReq,
  input logic [ID_W-1:0]  eventId,
  input logic             cntReady,
  input logic             countValid,
  input logic             ramWrEn,
  input logic [ID_W-1:0]  ramWrAddr,
  input logic [CNT_W-1:0] ramWrData
);
  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    cntReady |=> cntReady); // R1

  AST_CLEAR_WRITES_EACH_CYCLE: assert property (@(posedge clk) disable iff (rst)
    !cntReady |-> ramWrEn); // R1

  AST_CLEAR_WRITES_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ramWrEn && !cntReady) |-> (ramWrData == '0)); // R2

  AST_WRITEBACK_FROM_INC: assert property (@(posedge clk) disable iff (rst)
    (ramWrEn && cntReady) |-> ($past(incEvent && cntReady, 3) &&
                               ramWrAddr == $past(eventId, 3))); // R3

  AST_STROBE_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    countValid |-> $past(readReq && cntReady, 4)); // R5

  AST_NO_STROBE_UNREADY: assert property (@(posedge clk) disable iff (rst)
    !cntReady |-> !countValid); // R7
endmodule

bind evt_stat_counter evt_stat_counter_chk #(
  .ID_W (ID_W),
  .CNT_W(2 * HALF_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .incEvent  (incEvent),
  .readReq   (readReq),
  .eventId   (eventId),
  .cntReady  (cntReady),
  .countValid(countValid),
  .ramWrEn   (ramWrEn),
  .ramWrAddr (ramWrAddr),
  .ramWrData (ramWrData)
);

// File: tb/evt_stat_counter_tb.sv
module evt_stat_counter_tb;
  localparam int NUM_CNT = 256;
  localparam int HALF_W  = 4;
  localparam int CW      = 2 * HALF_W;
  localparam int IW      = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          incEvent = 1'b0;
  logic          readReq = 1'b0;
  logic [IW-1:0] eventId = '0;
  logic          cntReady;
  logic [CW-1:0] countOut;
  logic          countValid;

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  bit done    = 0;

  logic [CW-1:0] model [NUM_CNT];
  logic [CW-1:0] expVal[$];
  int            expCyc[$];
  string         expTag[$];

  evt_stat_counter #(.NUM_CNT(NUM_CNT), .HALF_W(HALF_W)) u_dut (
    .clk(clk), .rst(rst), .incEvent(incEvent), .readReq(readReq),
    .eventId(eventId), .cntReady(cntReady), .countOut(countOut),
    .countValid(countValid)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishUp();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  // One request cycle; the model updates only when the request is accepted
  task automatic op(input bit inc, input bit rd, input int id, input string tag);
    @(negedge clk);
    incEvent = inc;
    readReq  = rd;
    eventId  = IW'(id);
    if (cntReady && inc) model[id] = model[id] + 1'b1;
    if (cntReady && rd) begin
      expVal.push_back(model[id]);
      expCyc.push_back(cyc);
      expTag.push_back(tag);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) op(0, 0, 0, "");
  endtask

  task automatic readAll(input string tag);
    for (int i = 0; i < NUM_CNT; i++) op(0, 1, i, tag);
    idle(8);
  endtask

  // Response monitor: value, order and latency (R5, R8)
  always @(negedge clk) begin
    if (!rst && countValid) begin
      if (expVal.size() == 0) begin
        check(0, "R7", "strobe with no accepted read", 1, 0);
      end else begin
        automatic logic [CW-1:0] ev = expVal.pop_front();
        automatic int            ec = expCyc.pop_front();
        automatic string         et = expTag.pop_front();
        check(countOut == ev, et, "count value", countOut, ev);
        check(cyc - ec == 4, "R5", "read latency", cyc - ec, 4);
      end
    end
  end

  // Clear sweep: count edges to ready while pushing ignored requests (R1, R7)
  task automatic sweepWait();
    int n = 0;
    while (!cntReady && n < 2000) begin
      @(negedge clk);
      n++;
      if (!cntReady) begin
        incEvent = (n % 2) == 0;
        readReq  = (n % 2) == 1;
        eventId  = IW'(n);
      end else begin
        incEvent = 0;
        readReq  = 0;
      end
    end
    check(n == NUM_CNT, "R1", "edges to ready", n, NUM_CNT);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      finishUp();
    end
  end

  initial begin
    for (int i = 0; i < NUM_CNT; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(cntReady == 1'b0, "R1", "ready in reset", cntReady, 0);
    check(countValid == 1'b0, "R1", "strobe in reset", countValid, 0);
    rst = 1'b0;
    sweepWait();
    @(negedge clk);
    check(cntReady == 1'b1, "R1", "ready stays high", cntReady, 1);

    // R2/R8: all zero, reads back-to-back
    readAll("R2");

    // R3: near-exhaustive increment pattern over every counter
    for (int r = 0; r < 4; r++)
      for (int i = 0; i < NUM_CNT; i++)
        if (r <= (i % 4)) op(1, 0, i, "");
    idle(4);
    readAll("R3");

    // R4: carry into upper half and wrap, five counters rotating
    for (int r = 0; r < 300; r++) begin
      for (int k = 10; k < 15; k++) op(1, 0, k, "");
      if (model[10] == 8'd15 || model[10] == 8'd16 || model[10] == 8'd255 ||
          model[10] == 8'd0 || model[10] == 8'd1 || model[10] == 8'd31)
        op(0, 1, 10, "R4");
    end
    idle(8);
    readAll("R4");

    // R6: read after increment of the same counter at gaps 1..4
    for (int g = 1; g <= 4; g++)
      for (int id = 40; id < 44; id++) begin
        op(1, 0, id, "");
        idle(g - 1);
        op(0, 1, id, "R6");
        idle(6);
      end
    // R6/R8: increment then reads on each of the next four cycles
    op(1, 0, 77, "");
    for (int k = 0; k < 4; k++) op(0, 1, 77, "R6");
    idle(8);

    // R2/R7: reset with dirty memory, requests during sweep ignored
    idle(8);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < NUM_CNT; i++) model[i] = '0;
    sweepWait();
    readAll("R2");

    idle(10);
    check(expVal.size() == 0, "R5", "reads left unanswered", expVal.size(), 0);
    done = 1;
    finishUp();
  end
endmodule